// File: doc/BRIEF.md
# Multicart Outer Bank Address Composer

This block sits next to an existing inner bank controller on a game-cartridge bus and turns a two-game cartridge into two independent halves. It holds a single byte-wide outer register, loaded by CPU writes into the $6000–$7FFF window. One bit of that register picks which half of the program ROM (two 128 KiB halves of 256 KiB) and of the character ROM (two 256 KiB halves of 512 KiB) is visible. The inner controller's 8 KiB program bank and 1 KiB character bank indices are then merged underneath that bit.

A second register bit switches program banking away from the inner controller to a direct 32 KiB window. The window is chosen by a two-bit field of the register, and the CPU address picks the 8 KiB quarter inside it. Character banking always stays with the inner controller. The ROM addresses come straight from logic on the register and the bus inputs. The register is the only storage.

Top module: `mcb_outer_bank_top`

## Requirements
- R1: After a synchronous reset the register is zero: lower half selected, inner program banking, window 0.
- R2: A CPU write (`cpu_wr` high at a rising clock edge) with `cpu_addr[15:13]` equal to 3'b011 ($6000–$7FFF) loads the register, and the new value is in effect from the next cycle. The inner controller's work-RAM enable plays no part in this.
- R3: A write strobe with any address outside $6000–$7FFF leaves the register unchanged. So does an in-window address with `cpu_wr` low.
- R4: Data bit 6 is the half select, bit 5 is the program mode (0 inner, 1 direct), and bits 2:1 are the 32 KiB window. Bits 7, 4, 3 and 0 have no effect.
- R5: In inner mode, `prg_rom_addr` = {half, `inner_prg_bank[3:0]`, `cpu_addr[12:0]`}. The upper inner bits are dropped.
- R6: In direct mode, `prg_rom_addr` = {half, window, `cpu_addr[14:13]`, `cpu_addr[12:0]`}. A register value of $66 maps $8000, $A000, $C000 and $E000 to 8 KiB banks 28, 29, 30 and 31.
- R7: `chr_rom_addr` = {half, `inner_chr_bank[7:0]`, `ppu_addr[9:0]`} in both modes. With the half bit set and inner bank 10, this gives 1 KiB bank 266.
- R8: `prg_rd_en` is high exactly when `cpu_addr` is in $8000–$FFFF.
- R9: Both ROM addresses follow their inputs in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| ppu_addr | input | 14 | PPU address |
| inner_prg_bank | input | 8 | Inner controller's 8 KiB program bank index |
| inner_chr_bank | input | 8 | Inner controller's 1 KiB character bank index |
| prg_rom_addr | output | 18 | Program ROM byte address |
| chr_rom_addr | output | 19 | Character ROM byte address |
| prg_rd_en | output | 1 | Program ROM read enable |

## Verification
The hardest case to reach is the direct mode combined with the upper half and every window. In that case all four CPU quarters must land on distinct banks, and the inner bank input, which still carries a live value, must have no influence. The stimulus writes every pairing of half, mode and window through the CPU window. After each write it walks all four quarters while an inner index with set upper bits sits on the input. Separate scenarios strobe writes of a distinctive value at addresses just outside the window. They then read the unchanged mapping back through the ROM address outputs.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

    localparam int CPU_AW      = 16;
    localparam int DATA_W      = 8;
    localparam int PPU_AW      = 14;
    localparam int PRG_OFS_W   = 13;
    localparam int CHR_OFS_W   = 10;
    localparam int PRG_KEEP_W  = 4;
    localparam int CHR_KEEP_W  = 8;
    localparam int INNER_W     = 8;
    localparam int WIN_W       = 2;
    localparam int SLOT_W      = CPU_AW - 1 - PRG_OFS_W;
    localparam int DEC_W       = CPU_AW - PRG_OFS_W;

    localparam int BIT_HALF    = 6;
    localparam int BIT_MODE    = 5;
    localparam int WIN_LSB     = 1;

    localparam logic [DEC_W-1:0] REG_WINDOW_CODE = 3'b011;

    typedef enum logic {
        PRG_INNER  = 1'b0,
        PRG_DIRECT = 1'b1
    } prg_mode_e;

    typedef struct packed {
        logic             half;
        prg_mode_e        mode;
        logic [WIN_W-1:0] win;
    } outer_cfg_t;

    localparam outer_cfg_t CFG_RESET = '{half: 1'b0, mode: PRG_INNER, win: '0};

    function automatic outer_cfg_t cfg_from_byte(input logic [DATA_W-1:0] d);
        outer_cfg_t c;
        c.half = d[BIT_HALF];
        c.mode = prg_mode_e'(d[BIT_MODE]);
        c.win  = d[WIN_LSB +: WIN_W];
        return c;
    endfunction

    function automatic logic hits_reg_window(input logic [CPU_AW-1:0] a);
        return a[CPU_AW-1 -: DEC_W] == REG_WINDOW_CODE;
    endfunction

endpackage

// File: rtl/mcb_outer_reg.sv
module mcb_outer_reg
    import mcb_pkg::*;
#(
    parameter int AW = CPU_AW,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_data,
    input  logic          cpu_wr,
    output outer_cfg_t    cfg
);

    logic       hit;
    logic       load;
    outer_cfg_t cfg_q;

    always_comb begin
        hit  = hits_reg_window(cpu_addr);
        load = cpu_wr && hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (load) begin
            cfg_q <= cfg_from_byte(cpu_data);
        end
    end

    assign cfg = cfg_q;

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[AW-1 -: DEC_W] == REG_WINDOW_CODE)
        |=> (cfg.half == $past(cpu_data[BIT_HALF])
             && cfg.win == $past(cpu_data[WIN_LSB +: WIN_W])));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr && cpu_addr[AW-1 -: DEC_W] == REG_WINDOW_CODE)
        |=> $stable(cfg));

endmodule

// File: rtl/mcb_prg_compose.sv
module mcb_prg_compose
    import mcb_pkg::*;
#(
    parameter int AW     = CPU_AW,
    parameter int IW     = INNER_W,
    parameter int KEEP_W = PRG_KEEP_W,
    parameter int OFS_W  = PRG_OFS_W,
    localparam int OUT_W = 1 + KEEP_W + OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  outer_cfg_t       cfg,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [IW-1:0]    inner_bank,
    output logic [OUT_W-1:0] rom_addr,
    output logic             rd_en
);

    localparam int SW = AW - 1 - OFS_W;

    logic [KEEP_W-1:0] inner_part;
    logic [KEEP_W-1:0] direct_part;
    logic [KEEP_W-1:0] bank_sel;
    logic [SW-1:0]     slot;

    always_comb begin
        slot        = cpu_addr[OFS_W +: SW];
        inner_part  = inner_bank[KEEP_W-1:0];
        direct_part = KEEP_W'({cfg.win, slot});
        unique case (cfg.mode)
            PRG_DIRECT: bank_sel = direct_part;
            default:    bank_sel = inner_part;
        endcase
        rom_addr = {cfg.half, bank_sel, cpu_addr[OFS_W-1:0]};
        rd_en    = cpu_addr[AW-1];
    end

    p_direct_slot_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == PRG_DIRECT)
        |-> (rom_addr[OFS_W +: SW] == cpu_addr[OFS_W +: SW]
             && rom_addr[OFS_W + SW +: WIN_W] == cfg.win));

    p_inner_bank_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == PRG_INNER)
        |-> rom_addr[OFS_W +: KEEP_W] == inner_bank[KEEP_W-1:0]);

endmodule

// File: rtl/mcb_chr_compose.sv
module mcb_chr_compose
    import mcb_pkg::*;
#(
    parameter int PW     = PPU_AW,
    parameter int IW     = INNER_W,
    parameter int KEEP_W = CHR_KEEP_W,
    parameter int OFS_W  = CHR_OFS_W,
    localparam int OUT_W = 1 + KEEP_W + OFS_W
) (
    input  outer_cfg_t       cfg,
    input  logic [PW-1:0]    ppu_addr,
    input  logic [IW-1:0]    inner_bank,
    output logic [OUT_W-1:0] rom_addr
);

    logic [KEEP_W-1:0] bank_sel;

    always_comb begin
        bank_sel = inner_bank[KEEP_W-1:0];
        rom_addr = {cfg.half, bank_sel, ppu_addr[OFS_W-1:0]};
    end

endmodule

// File: rtl/mcb_outer_bank_top.sv
module mcb_outer_bank_top
    import mcb_pkg::*;
#(
    parameter int AW        = CPU_AW,
    parameter int DW        = DATA_W,
    parameter int PW        = PPU_AW,
    parameter int IW        = INNER_W,
    parameter int PRG_KEEP  = PRG_KEEP_W,
    parameter int CHR_KEEP  = CHR_KEEP_W,
    parameter int PRG_OFS   = PRG_OFS_W,
    parameter int CHR_OFS   = CHR_OFS_W,
    localparam int PRG_AW   = 1 + PRG_KEEP + PRG_OFS,
    localparam int CHR_AW   = 1 + CHR_KEEP + CHR_OFS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [DW-1:0]     cpu_data,
    input  logic              cpu_wr,
    input  logic [PW-1:0]     ppu_addr,
    input  logic [IW-1:0]     inner_prg_bank,
    input  logic [IW-1:0]     inner_chr_bank,
    output logic [PRG_AW-1:0] prg_rom_addr,
    output logic [CHR_AW-1:0] chr_rom_addr,
    output logic              prg_rd_en
);

    outer_cfg_t cfg;

    mcb_outer_reg #(.AW(AW), .DW(DW)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_wr   (cpu_wr),
        .cfg      (cfg)
    );

    mcb_prg_compose #(.AW(AW), .IW(IW), .KEEP_W(PRG_KEEP), .OFS_W(PRG_OFS)) u_prg (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .cpu_addr   (cpu_addr),
        .inner_bank (inner_prg_bank),
        .rom_addr   (prg_rom_addr),
        .rd_en      (prg_rd_en)
    );

    mcb_chr_compose #(.PW(PW), .IW(IW), .KEEP_W(CHR_KEEP), .OFS_W(CHR_OFS)) u_chr (
        .cfg        (cfg),
        .ppu_addr   (ppu_addr),
        .inner_bank (inner_chr_bank),
        .rom_addr   (chr_rom_addr)
    );

    p_shared_half_r7: assert property (@(posedge clk) disable iff (rst)
        chr_rom_addr[CHR_AW-1] == prg_rom_addr[PRG_AW-1]);

endmodule

// File: tb/sim_mcb_outer_bank_top.sv
module sim_mcb_outer_bank_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [13:0] ppu_addr = 14'h0000;
    logic [7:0]  inner_prg_bank = 8'h00;
    logic [7:0]  inner_chr_bank = 8'h00;
    logic [17:0] prg_rom_addr;
    logic [18:0] chr_rom_addr;
    logic        prg_rd_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mcb_outer_bank_top u0 (
        .clk            (clk),
        .rst            (rst),
        .cpu_addr       (cpu_addr),
        .cpu_data       (cpu_data),
        .cpu_wr         (cpu_wr),
        .ppu_addr       (ppu_addr),
        .inner_prg_bank (inner_prg_bank),
        .inner_chr_bank (inner_chr_bank),
        .prg_rom_addr   (prg_rom_addr),
        .chr_rom_addr   (chr_rom_addr),
        .prg_rd_en      (prg_rd_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] exp_prg(input logic [7:0] r, input logic [15:0] a,
                                            input logic [7:0] inner);
        if (r[5]) return {r[6], r[2:1], a[14:13], a[12:0]};
        return {r[6], inner[3:0], a[12:0]};
    endfunction

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input logic strobe);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_wr   = strobe;
        @(negedge clk);
        cpu_wr   = 1'b0;
        cpu_addr = 16'h0000;
    endtask

    task automatic probe_prg(input string req, input logic [7:0] r, input logic [15:0] a);
        cpu_addr = a;
        #1;
        chk(req, 32'(prg_rom_addr), 32'(exp_prg(r, a, inner_prg_bank)));
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        inner_prg_bank = 8'h1F;
        probe_prg("R1 reset E000 bank 15", 8'h00, 16'hE000);
        chk("R1 reset bank index", 32'(prg_rom_addr[17:13]), 32'd15);
        inner_chr_bank = 8'h0A;
        ppu_addr = 14'h1001;
        #1;
        chk("R1 reset chr half", 32'(chr_rom_addr), {13'd0, 9'd10, 10'h001});
    endtask

    task automatic t_sweep;
        logic [7:0] r;
        logic [15:0] a;
        inner_prg_bank = 8'hB6;
        inner_chr_bank = 8'hC3;
        for (int o = 0; o < 2; o++) begin
            for (int m = 0; m < 2; m++) begin
                for (int pp = 0; pp < 4; pp++) begin
                    r = 8'((o << 6) | (m << 5) | (pp << 1));
                    cpu_write(16'h6000, r, 1'b1);
                    for (int w = 0; w < 4; w++) begin
                        a = 16'h8000 | 16'(w << 13) | 16'h0123;
                        if (m == 1) probe_prg("R6 direct sweep", r, a);
                        else        probe_prg("R5 inner sweep", r, a);
                    end
                    ppu_addr = 14'h0ABC;
                    #1;
                    chk("R7 chr sweep", 32'(chr_rom_addr), 32'({o[0], 8'hC3, 10'h2BC}));
                end
            end
        end
    endtask

    task automatic t_example_66;
        cpu_write(16'h7FFF, 8'h66, 1'b1);
        for (int w = 0; w < 4; w++) begin
            cpu_addr = 16'h8000 | 16'(w << 13);
            #1;
            chk("R6 $66 bank", 32'(prg_rom_addr[17:13]), 32'(28 + w));
        end
    endtask

    task automatic t_outside;
        logic [15:0] addrs [4];
        addrs[0] = 16'h5FFF; addrs[1] = 16'h8000; addrs[2] = 16'h4000; addrs[3] = 16'hE000;
        cpu_write(16'h6000, 8'h00, 1'b1);
        inner_prg_bank = 8'h05;
        for (int i = 0; i < 4; i++) begin
            cpu_write(addrs[i], 8'h66, 1'b1);
            probe_prg("R3 outside write ignored", 8'h00, 16'hE000);
        end
        cpu_write(16'h6000, 8'h66, 1'b0);
        probe_prg("R3 no strobe ignored", 8'h00, 16'hA000);
    endtask

    task automatic t_ignored_bits;
        cpu_write(16'h6ABC, 8'h99, 1'b1);
        inner_prg_bank = 8'h07;
        probe_prg("R4 bits 7,4,3,0 ignored", 8'h00, 16'hC000);
        cpu_write(16'h6001, 8'hC0, 1'b1);
        probe_prg("R4 half bit only", 8'h40, 16'hC000);
        chk("R4 half bit set", 32'(prg_rom_addr[17]), 32'd1);
    endtask

    task automatic t_chr_266;
        cpu_write(16'h6000, 8'h40, 1'b1);
        inner_chr_bank = 8'd10;
        ppu_addr = 14'h1001;
        #1;
        chk("R7 bank 266", 32'(chr_rom_addr[18:10]), 32'd266);
        inner_chr_bank = 8'd11;
        #1;
        chk("R9 combinational chr", 32'(chr_rom_addr[18:10]), 32'd267);
        inner_prg_bank = 8'h0C;
        cpu_addr = 16'h9000;
        #1;
        chk("R9 combinational prg", 32'(prg_rom_addr[17:13]), 32'd28);
    endtask

    task automatic t_rden;
        logic [15:0] a [5];
        logic        e [5];
        a[0] = 16'h7FFF; e[0] = 1'b0;
        a[1] = 16'h8000; e[1] = 1'b1;
        a[2] = 16'hFFFF; e[2] = 1'b1;
        a[3] = 16'h6000; e[3] = 1'b0;
        a[4] = 16'h0000; e[4] = 1'b0;
        for (int i = 0; i < 5; i++) begin
            cpu_addr = a[i];
            #1;
            chk("R8 read enable", 32'(prg_rd_en), 32'(e[i]));
        end
    endtask

    task automatic t_write_timing;
        cpu_write(16'h6000, 8'h00, 1'b1);
        @(negedge clk);
        cpu_addr = 16'h6000;
        cpu_data = 8'h40;
        cpu_wr   = 1'b1;
        #1;
        chk("R2 not before edge", 32'(chr_rom_addr[18]), 32'd0);
        @(negedge clk);
        cpu_wr = 1'b0;
        #1;
        chk("R2 after edge", 32'(chr_rom_addr[18]), 32'd1);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_example_66();
        t_outside();
        t_ignored_bits();
        t_chr_266();
        t_rden();
        t_write_timing();
        t_reset();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule